// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of sampled signal words into a circular memory. Samples are kept both before and after a trigger event. When the buffer is armed, a configured position value sets what share of the buffer is kept for samples after the trigger, in steps of 1/512 of the depth. Until the trigger arrives the memory wraps freely. Once the trigger sample and the samples that follow it have been written, the buffer freezes and raises `done`.

An external trigger sequencer controls capture with three pulses: `trc_start`, `trc_stop` and `trc_single`. A mode bit latched at arm time decides whether every clock cycle is stored or only the cycles that carry a valid transfer strobe. After capture, software reads the samples through an address/data port. Address 0 always returns the oldest surviving sample, and higher addresses return newer ones. The port also reports how many entries are valid and where the trigger sample sits in that order.

Top module: `trace_capture`

## Requirements
- R1: After reset, `done` is 0 and `stored` is 0. No sample is written before the first `arm` pulse, and `trig` has no effect until then.
- R2: An `arm` pulse latches the position value p. Values 0 and above 511 are clamped to 1 and 511 respectively. The post-trigger length is N = floor(DEPTH*p/512), raised to 1 if that gives 0. `done` rises at the clock edge that writes the N-th sample counted from the trigger sample, which itself counts as the first.
- R3: With `cfg_valid_only`=1 at arm time, a cycle is stored only when `smp_valid` is 1. With 0, every enabled cycle is stored.
- R4: `arm` clears the fill count and the trigger state and enables capture. `trc_stop` disables capture from the next cycle, and `trc_start` re-enables it. If both arrive together, stop wins.
- R5: `trc_single` stores the current sample in that cycle, even while capture is disabled and whatever the valid strobe is.
- R6: Once `done` is 1, no further sample is written and `stored` and the readout contents stay unchanged until the next `arm`.
- R7: Readout is registered. The value `rd_data` sampled one clock after `rd_addr`=a is the a-th oldest surviving sample, with a=0 the oldest.
- R8: `stored` gives the number of valid entries and saturates at DEPTH. A trigger that comes before the buffer fills is still honoured, and the oldest entry is then the first sample stored after arm.
- R9: When `done` is 1, `trig_idx` is the readout address of the trigger sample.
- R10: The trigger sample is the first sample stored in or after the cycle where `trig` is first seen after arm. Later `trig` pulses in the same capture are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse: restart capture and latch configuration |
| cfg_pos | input | 10 | Post-trigger position in 1/512 units |
| cfg_valid_only | input | 1 | 1: store only cycles with smp_valid |
| smp_data | input | DATA_W | Sample word |
| smp_valid | input | 1 | Valid-transfer strobe for the sample |
| trig | input | 1 | Trigger event |
| trc_start | input | 1 | Enable capture |
| trc_stop | input | 1 | Disable capture |
| trc_single | input | 1 | Store this cycle's sample unconditionally |
| rd_addr | input | ADDR_W | Readout address, 0 = oldest |
| rd_data | output | DATA_W | Registered readout data |
| done | output | 1 | Capture complete |
| stored | output | ADDR_W+1 | Number of valid entries |
| trig_idx | output | ADDR_W | Readout address of the trigger sample |

## Verification
A wrong post-length calculation or a wrong trigger latch shows up on the ports as `done` rising at the wrong cycle. A cycle-by-cycle comparison of `done` and `stored` catches this on the very edge where it happens. A wrong write pointer or a wrong oldest-entry selection stays hidden while capture runs. It appears only at readout, as `rd_data` not matching the sample sequence or as `trig_idx` being off by the pointer error. The sweep therefore reads back every valid entry of every run, across clamped and unclamped positions, both storage modes, early triggers and gated capture.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int POS_W = 10;
  localparam int FRAC  = 512;

  // Force a position value into the legal 1..FRAC-1 range
  function automatic int clamp_pos(input logic [POS_W-1:0] p);
    if (p == '0) return 1;
    if (int'(p) > FRAC - 1) return FRAC - 1;
    return int'(p);
  endfunction

  // Samples kept from the trigger sample onwards (at least one)
  function automatic int post_len(input logic [POS_W-1:0] p, input int depth);
    int v;
    v = (depth * clamp_pos(p)) / FRAC;
    if (v < 1) v = 1;
    return v;
  endfunction
endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [9:0]        cfg_pos,
  input  logic              cfg_valid_only,
  input  logic              smp_valid,
  input  logic              trig,
  input  logic              trc_start,
  input  logic              trc_stop,
  input  logic              trc_single,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W:0]   stored,
  output logic [ADDR_W-1:0] trig_phys,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          armed_q, en_q, vo_q, trigp_q, trigd_q, done_q;
  logic [CW-1:0] post_q, rem_q, stored_q;
  logic [ADDR_W-1:0] ptr_q, tphys_q;

  // named internal events
  logic qual, trig_ok, trig_store, post_store, trig_wait;
  logic [CW-1:0] post_calc;

  assign post_calc  = CW'(trc_pkg::post_len(cfg_pos, DEPTH));
  assign qual       = vo_q ? smp_valid : 1'b1;
  assign wr_en      = armed_q & ~done_q & ((en_q & qual) | trc_single);
  assign trig_ok    = armed_q & ~done_q & ~trigd_q;
  assign trig_store = wr_en & trig_ok & (trig | trigp_q);
  assign post_store = wr_en & trigd_q;
  assign trig_wait  = trig_ok & trig & ~wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      en_q     <= 1'b0;
      vo_q     <= 1'b0;
      trigp_q  <= 1'b0;
      trigd_q  <= 1'b0;
      done_q   <= 1'b0;
      post_q   <= '0;
      rem_q    <= '0;
      stored_q <= '0;
      ptr_q    <= '0;
      tphys_q  <= '0;
    end else if (arm) begin
      armed_q  <= 1'b1;
      en_q     <= 1'b1;
      vo_q     <= cfg_valid_only;
      trigp_q  <= 1'b0;
      trigd_q  <= 1'b0;
      done_q   <= 1'b0;
      post_q   <= post_calc;
      rem_q    <= '0;
      stored_q <= '0;
      ptr_q    <= '0;
      tphys_q  <= '0;
    end else begin
      if (trc_stop)       en_q <= 1'b0;
      else if (trc_start) en_q <= 1'b1;

      if (wr_en) begin
        ptr_q <= ptr_q + 1'b1;
        if (stored_q != FULL_CNT) stored_q <= stored_q + 1'b1;
      end

      if (trig_wait) trigp_q <= 1'b1;

      if (trig_store) begin
        trigd_q <= 1'b1;
        trigp_q <= 1'b0;
        tphys_q <= ptr_q;
        rem_q   <= post_q - 1'b1;
        if (post_q == CW'(1)) done_q <= 1'b1;
      end else if (post_store) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign wr_ptr    = ptr_q;
  assign stored    = stored_q;
  assign trig_phys = tphys_q;
  assign done      = done_q;

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigd_q |-> (rem_q < post_q));

  // R8
  fill_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stored_q[ADDR_W] |-> (ptr_q == stored_q[ADDR_W-1:0]));

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !arm) |=> ($stable(ptr_q) && $stable(stored_q)));

  // R2
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(wr_en));

  // R10
  single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trigd_q && !arm) |=> $stable(tphys_q));
endmodule

// File: rtl/trc_mem.sv
module trc_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/trc_rdmap.sv
module trc_rdmap #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [ADDR_W:0]   stored,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [ADDR_W-1:0] trig_phys,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] rd_phys,
  output logic [ADDR_W-1:0] trig_idx
);
  logic              full;
  logic [ADDR_W-1:0] oldest;

  assign full     = stored[ADDR_W];
  assign oldest   = full ? wr_ptr : '0;
  assign rd_phys  = oldest + rd_addr;
  assign trig_idx = trig_phys - oldest;

  // R9
  trig_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full) |-> ({1'b0, trig_idx} < stored));
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [9:0]        cfg_pos,
  input  logic              cfg_valid_only,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  input  logic              trig,
  input  logic              trc_start,
  input  logic              trc_stop,
  input  logic              trc_single,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W:0]   stored,
  output logic [ADDR_W-1:0] trig_idx
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_ptr, trig_phys, rd_phys;

  trc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_pos(cfg_pos),
    .cfg_valid_only(cfg_valid_only), .smp_valid(smp_valid), .trig(trig),
    .trc_start(trc_start), .trc_stop(trc_stop), .trc_single(trc_single),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .stored(stored),
    .trig_phys(trig_phys), .done(done)
  );

  trc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(smp_data),
    .raddr(rd_phys), .rdata(rd_data)
  );

  trc_rdmap #(.ADDR_W(ADDR_W)) u_rdmap (
    .clk(clk), .rst_n(rst_n), .done(done), .stored(stored),
    .wr_ptr(wr_ptr), .trig_phys(trig_phys), .rd_addr(rd_addr),
    .rd_phys(rd_phys), .trig_idx(trig_idx)
  );

  // R6
  no_store_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |-> !wr_en);
endmodule

// File: tb/test_trace_capture.sv
`timescale 1ns/1ps
module test_trace_capture;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, cfg_valid_only = 0, smp_valid = 0, trig = 0;
  logic trc_start = 0, trc_stop = 0, trc_single = 0;
  logic [9:0] cfg_pos = '0;
  logic [DW-1:0] smp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic done;
  logic [AW:0] stored;
  logic [AW-1:0] trig_idx;

  trace_capture #(.DATA_W(DW), .ADDR_W(AW)) i_trace_capture (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_pos(cfg_pos),
    .cfg_valid_only(cfg_valid_only), .smp_data(smp_data), .smp_valid(smp_valid),
    .trig(trig), .trc_start(trc_start), .trc_stop(trc_stop), .trc_single(trc_single),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .stored(stored), .trig_idx(trig_idx)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [DW-1:0] hist [0:255];
  int hcnt, tidx, m_rem, m_post;
  bit m_done, m_trigd, m_trigp, m_en, m_vo;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected post length: clamp, scale by depth in 1/512 steps, floor, at least one
  function automatic int exp_post(input int p);
    int c;
    c = (p < 1) ? 1 : ((p > 511) ? 511 : p);
    c = (c * DEPTH) >> 9;
    return (c == 0) ? 1 : c;
  endfunction

  task automatic run_case(input int pos, input bit vo, input int trig_at,
                          input int stop_at, input int start_at,
                          input int single_at, input int vper, input int run_id);
    int valid, base;
    @(negedge clk);
    cfg_pos = 10'(pos); cfg_valid_only = vo; arm = 1;
    @(negedge clk);
    arm = 0;
    hcnt = 0; tidx = 0; m_rem = 0; m_done = 0; m_trigd = 0; m_trigp = 0;
    m_en = 1; m_vo = vo; m_post = exp_post(pos);
    chk(stored == 0, "R4 stored after arm", stored, 0);
    chk(done == 0, "R4 done after arm", done, 0);
    for (int c = 0; c < 60; c++) begin
      bit q, st;
      smp_data   = {run_id[7:0], 24'(c)};
      smp_valid  = (vper == 0) ? 1'b1 : ((c % vper) != 0);
      trig       = (c == trig_at) || (c == trig_at + 3);
      trc_stop   = (c == stop_at);
      trc_start  = (c == start_at);
      trc_single = (c == single_at);
      q  = m_vo ? smp_valid : 1'b1;
      st = !m_done && ((m_en && q) || trc_single);
      if (st) begin
        hist[hcnt] = smp_data;
        hcnt++;
        if (!m_trigd && (trig || m_trigp)) begin
          m_trigd = 1; m_trigp = 0; tidx = hcnt - 1; m_rem = m_post - 1;
          if (m_rem == 0) m_done = 1;
        end else if (m_trigd) begin
          m_rem--;
          if (m_rem == 0) m_done = 1;
        end
      end else if (!m_done && !m_trigd && trig) begin
        m_trigp = 1;
      end
      if (trc_stop) m_en = 0;
      else if (trc_start) m_en = 1;
      @(negedge clk);
      chk(done == m_done, "R2 done timing", done, m_done);
      chk(int'(stored) == ((hcnt < DEPTH) ? hcnt : DEPTH), "R3 R5 R6 fill count",
          stored, (hcnt < DEPTH) ? hcnt : DEPTH);
    end
    trig = 0; trc_stop = 0; trc_start = 0; trc_single = 0; smp_valid = 0;
    valid = (hcnt < DEPTH) ? hcnt : DEPTH;
    base  = hcnt - valid;
    chk(m_done == 1'b1, "R2 capture finished in model", m_done, 1);
    chk(int'(stored) == valid, "R8 valid entries", stored, valid);
    chk(int'(trig_idx) == tidx - base, "R9 R10 trigger index", trig_idx, tidx - base);
    for (int a = 0; a < valid; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      chk(rd_data == hist[base + a], "R7 oldest-first readout", rd_data, hist[base + a]);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0, "R1 done at reset", done, 0);
    chk(stored == 0, "R1 stored at reset", stored, 0);
    // R1: samples and trigger before the first arm are ignored
    trig = 1; smp_valid = 1; trc_single = 1; smp_data = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    trig = 0; trc_single = 0;
    chk(stored == 0, "R1 no store before arm", stored, 0);
    chk(done == 0, "R1 no done before arm", done, 0);

    // R2 clamp and scaling corners
    run_case(0,    0, 20, -1, -1, -1, 0, 1);
    run_case(1,    0, 20, -1, -1, -1, 0, 2);
    run_case(32,   0, 20, -1, -1, -1, 0, 3);
    run_case(511,  0, 24, -1, -1, -1, 0, 4);
    run_case(512,  0, 24, -1, -1, -1, 0, 5);
    run_case(1023, 0, 24, -1, -1, -1, 0, 6);
    // R3 valid-only storage
    run_case(100,  1, 10, -1, -1, -1, 3, 7);
    run_case(480,  1, 24, -1, -1, -1, 3, 8);
    // R8 early trigger, R10 trigger on first cycle
    run_case(128,  0, 2,  -1, -1, -1, 0, 9);
    run_case(32,   0, 0,  -1, -1, -1, 0, 10);
    // R4 R5 gating with single samples and trigger pending while stopped
    run_case(256,  0, 15, 5, 30, 10, 0, 11);
    run_case(256,  0, 15, 5, 30, 20, 0, 12);
    run_case(200,  1, 8,  3, 12, 6, 2, 13);
    // sweep of positions and modes
    for (int p = 0; p < 1024; p += 41)
      run_case(p, p[0], p % 23, -1, -1, -1, p[0] ? 3 : 0, 20 + p / 41);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule